// File: doc/BRIEF.md
# Phase-Sampler Jitter Statistics Collector

This block turns the captured state of a row of fifteen offset phase samplers into jitter statistics. The samplers sit in a line around a centre element. Seven of them see the data edge with a growing positive offset and seven with a growing negative offset, because the data is delayed by a larger amount at each step away from the centre. On each strobe the block compares every pair of neighbouring samples with XOR to find where the row changes from ones to zeros. That position is the phase bin of the sample. A row with a bubble is an invalid pattern. It is counted as an error and is not binned.

Two collection modes share the decoder. In histogram mode each accepted sample adds one to a saturating counter for its bin. In graph mode the bins are written, in arrival order, into a fixed-depth buffer that freezes when it is full. Both modes run alongside a small up/down filter. The filter watches the centre sampler and asks an external delay counter to step the reference delay up or down when the accumulated bias reaches a threshold. Software reads the counters and the buffer through a combinational read port.

Top module: `phase_jitter_collector`

## Requirements
- R1: Bit i of `smp_taps` is sampler i. A valid pattern has ones in positions 0..k-1 and zeros above them. It decodes to bin k, for k from 0 to 15.
- R2: When `graph_mode` is 0, each accepted sample adds one to the counter of its bin. Counter b is read at `rd_addr` = b (0..15), in the same cycle the address is applied.
- R3: An all-zero pattern goes to bin 0 and an all-one pattern goes to bin 15. These are the two end-of-range bins.
- R4: Bin counters and the error counter stop at 2^CNT_W-1 and do not wrap.
- R5: A pattern is an error if any position i has `smp_taps[i]`=0 and `smp_taps[i+1]`=1. An error sample is neither binned nor stored, and it has no effect on the filter. In either mode it adds one to the error counter, which is read at `rd_addr` = 16.
- R6: `clear` zeroes all bin counters, the error counter, the graph fill level and `graph_done` at the next edge. A sample strobed in the same cycle as `clear` is discarded.
- R7: When `graph_mode` is 1, accepted samples are stored in order. Entry n is read at `rd_addr` = 32+n, with the bin in the low 4 bits. Histogram counters are left unchanged.
- R8: Once GDEPTH entries are stored, `graph_done` is high and further samples are discarded until `clear`.
- R9: Each accepted sample adds +1 to the filter if `smp_taps[7]` is 1, and -1 if it is 0. When the sum reaches +THRESH, `dly_inc` pulses for one cycle after that edge and the sum returns to 0. When it reaches -THRESH, `dly_dec` does the same. The filter ignores `clear` and `graph_mode`.
- R10: After reset every readable location is 0, and `graph_done`, `dly_inc` and `dly_dec` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Strobe: `smp_taps` holds a new sample |
| smp_taps | input | 15 | Captured sampler outputs, bit 0 lowest offset |
| graph_mode | input | 1 | 0 histogram, 1 time-ordered graph |
| clear | input | 1 | Zero the statistics |
| rd_addr | input | ADDR_W | Read address: bins, error count, graph entries |
| rd_data | output | CNT_W | Read data for `rd_addr` |
| graph_done | output | 1 | Graph buffer full |
| dly_inc | output | 1 | One-cycle request to lengthen the reference delay |
| dly_dec | output | 1 | One-cycle request to shorten the reference delay |

## Verification
A clear and a sample strobe can arrive on the same edge, and the clear must win. The bench fills a bin, then raises `clear` together with a valid sample for that bin. It expects the bin to read zero afterwards. A fill-level collision is checked the same way: the graph buffer is filled up to `graph_done`, then further valid and invalid samples are applied. The stored entries must stay unchanged while the error count still grows.

// File: rtl/pjc_pkg.sv
package pjc_pkg;

    localparam int TAPS   = 15;
    localparam int NBIN   = TAPS + 1;
    localparam int BIN_W  = $clog2(NBIN);
    localparam int CENTER = TAPS / 2;

    typedef logic [TAPS-1:0]  taps_t;
    typedef logic [BIN_W-1:0] bin_t;

    typedef struct packed {
        logic take;   // valid, well-formed sample
        logic err;    // valid, malformed sample
        logic up;     // centre sampler state
        bin_t bin;
    } smp_t;

    // a zero directly below a one cannot occur in a clean thermometer row
    function automatic logic has_bubble(input taps_t t);
        for (int i = 0; i < TAPS - 1; i++) begin
            if (!t[i] && t[i+1]) return 1'b1;
        end
        return 1'b0;
    endfunction

    // neighbour XOR marks the edge; no edge means an end-of-range bin
    function automatic bin_t locate_edge(input taps_t t);
        bin_t b;
        b = t[0] ? bin_t'(TAPS) : bin_t'(0);
        for (int i = 0; i < TAPS - 1; i++) begin
            if (t[i] ^ t[i+1]) b = bin_t'(i + 1);
        end
        return b;
    endfunction

endpackage

// File: rtl/pjc_decode.sv
module pjc_decode
    import pjc_pkg::*;
(
    input  logic  valid,
    input  taps_t taps,
    output smp_t  smp
);
    logic bad;

    always_comb begin
        bad      = has_bubble(taps);
        smp.err  = valid && bad;
        smp.take = valid && !bad;
        smp.up   = taps[CENTER];
        smp.bin  = locate_edge(taps);
    end
endmodule

// File: rtl/pjc_hist.sv
module pjc_hist
    import pjc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             hit,
    input  bin_t             bin,
    input  logic             miss,
    output logic [CNT_W-1:0] cnt [NBIN],
    output logic [CNT_W-1:0] err_cnt
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    for (genvar b = 0; b < NBIN; b++) begin : g_bin
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                cnt[b] <= '0;
            end else if (hit && bin == bin_t'(b) && cnt[b] != TOP) begin
                cnt[b] <= cnt[b] + 1'b1;
            end
        end

        p_mono_r2: assert property (@(posedge clk) disable iff (rst)
            !clear |=> cnt[b] >= $past(cnt[b]));
        p_sat_r4: assert property (@(posedge clk) disable iff (rst)
            (cnt[b] == TOP && !clear) |=> cnt[b] == TOP);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            err_cnt <= '0;
        end else if (miss && err_cnt != TOP) begin
            err_cnt <= err_cnt + 1'b1;
        end
    end

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        clear |=> err_cnt == '0);
endmodule

// File: rtl/pjc_graph.sv
module pjc_graph
    import pjc_pkg::*;
#(
    parameter int GDEPTH = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic wr,
    input  bin_t bin,
    output bin_t ent [GDEPTH],
    output logic done
);
    localparam int PW = $clog2(GDEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(GDEPTH - 1);

    logic [PW-1:0] fill;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fill <= '0;
            done <= 1'b0;
        end else if (wr && !done) begin
            fill <= fill + 1'b1;
            done <= (fill == LAST);
        end
    end

    for (genvar e = 0; e < GDEPTH; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[e] <= '0;
            end else if (wr && !done && !clear && fill == PW'(e)) begin
                ent[e] <= bin;
            end
        end
    end

    p_done_full_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> fill == PW'(GDEPTH));
    p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !clear) |=> $stable(fill) && done);
endmodule

// File: rtl/pjc_lpf.sv
module pjc_lpf #(
    parameter int THRESH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic up,
    output logic inc,
    output logic dec
);
    localparam int AW = $clog2(THRESH + 1) + 2;
    localparam logic signed [AW-1:0] POS = AW'(THRESH);
    localparam logic signed [AW-1:0] NEG = -AW'(THRESH);

    logic signed [AW-1:0] acc, nxt;

    always_comb nxt = up ? acc + AW'(1) : acc - AW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            inc <= 1'b0;
            dec <= 1'b0;
        end else begin
            inc <= 1'b0;
            dec <= 1'b0;
            if (step) begin
                if (nxt == POS) begin
                    inc <= 1'b1;
                    acc <= '0;
                end else if (nxt == NEG) begin
                    dec <= 1'b1;
                    acc <= '0;
                end else begin
                    acc <= nxt;
                end
            end
        end
    end

    p_one_dir_r9: assert property (@(posedge clk) disable iff (rst)
        !(inc && dec));
    p_acc_bound_r9: assert property (@(posedge clk) disable iff (rst)
        acc < POS && acc > NEG);
    p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        inc |-> acc == '0);
endmodule

// File: rtl/phase_jitter_collector.sv
module phase_jitter_collector
    import pjc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int GDEPTH = 32,
    parameter int THRESH = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [14:0]       smp_taps,
    input  logic              graph_mode,
    input  logic              clear,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              graph_done,
    output logic              dly_inc,
    output logic              dly_dec
);
    localparam int ERR_ADDR = NBIN;
    localparam int GBASE    = 2 * NBIN;

    smp_t             smp;
    logic [CNT_W-1:0] cnt [NBIN];
    logic [CNT_W-1:0] err_cnt;
    bin_t             ent [GDEPTH];

    pjc_decode u_dec (
        .valid (smp_valid),
        .taps  (smp_taps),
        .smp   (smp)
    );

    pjc_hist #(.CNT_W(CNT_W)) u_hist (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .hit     (smp.take && !graph_mode),
        .bin     (smp.bin),
        .miss    (smp.err),
        .cnt     (cnt),
        .err_cnt (err_cnt)
    );

    pjc_graph #(.GDEPTH(GDEPTH)) u_graph (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .wr    (smp.take && graph_mode),
        .bin   (smp.bin),
        .ent   (ent),
        .done  (graph_done)
    );

    pjc_lpf #(.THRESH(THRESH)) u_lpf (
        .clk  (clk),
        .rst  (rst),
        .step (smp.take),
        .up   (smp.up),
        .inc  (dly_inc),
        .dec  (dly_dec)
    );

    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) < NBIN) begin
            rd_data = cnt[rd_addr[BIN_W-1:0]];
        end else if (int'(rd_addr) == ERR_ADDR) begin
            rd_data = err_cnt;
        end else begin
            for (int e = 0; e < GDEPTH; e++) begin
                if (int'(rd_addr) == GBASE + e) rd_data = CNT_W'(ent[e]);
            end
        end
    end

    p_err_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && pjc_pkg::has_bubble(smp_taps)) |=> !dly_inc && !dly_dec);
endmodule

// File: tb/phase_jitter_collector_bench.sv
module phase_jitter_collector_bench;
    localparam int PERIOD = 10;
    localparam int CW = 5;
    localparam int GD = 8;
    localparam int TH = 3;
    localparam int MAXC = (1 << CW) - 1;

    logic clk = 0, rst = 1, smp_valid = 0, graph_mode = 0, clear = 0;
    logic [14:0] smp_taps = '0;
    logic [5:0] rd_addr = '0;
    logic [CW-1:0] rd_data;
    logic graph_done, dly_inc, dly_dec;

    int n_chk = 0, n_bad = 0;
    bit ended = 0;

    always #(PERIOD/2) clk = ~clk;

    phase_jitter_collector #(.CNT_W(CW), .GDEPTH(GD), .THRESH(TH), .ADDR_W(6))
    u_phase_jitter_collector (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_taps(smp_taps),
        .graph_mode(graph_mode), .clear(clear), .rd_addr(rd_addr),
        .rd_data(rd_data), .graph_done(graph_done), .dly_inc(dly_inc), .dly_dec(dly_dec)
    );

    function automatic logic [14:0] therm(input int k);
        return 15'((32'd1 << k) - 1);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output int v);
        rd_addr = 6'(a);
        #1;
        v = int'(rd_data);
    endtask

    task automatic send(input logic [14:0] p, input logic clr);
        @(negedge clk);
        smp_taps = p; smp_valid = 1; clear = clr;
        @(negedge clk);
        smp_valid = 0; clear = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk); rst = 0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        int v;
        int acc;
        logic [14:0] seq [12];
        do_reset();

        // R10: reset state
        for (int a = 0; a < 17; a++) begin rd(a, v); check("R10 bin/err", v, 0); end
        for (int e = 0; e < GD; e++) begin rd(32 + e, v); check("R10 graph", v, 0); end
        check("R10 done", int'(graph_done), 0);
        check("R10 inc", int'(dly_inc), 0);
        check("R10 dec", int'(dly_dec), 0);

        // R1 R2 R3: bin k receives k+1 samples
        for (int k = 0; k < 16; k++)
            for (int j = 0; j <= k; j++) send(therm(k), 0);
        for (int k = 0; k < 16; k++) begin
            rd(k, v);
            check((k == 0 || k == 15) ? "R3 end bin" : "R1 R2 bin count", v, k + 1);
        end

        // R6: clear alone
        @(negedge clk); clear = 1; @(negedge clk); clear = 0;
        for (int a = 0; a < 17; a++) begin rd(a, v); check("R6 clear", v, 0); end

        // R5 R1: exhaustive pattern sweep, validity computed arithmetically
        for (int p = 0; p < 32768; p++) send(15'(p), 0);
        for (int k = 0; k < 16; k++) begin rd(k, v); check("R1 sweep bin", v, 1); end
        rd(16, v); check("R5 R4 error count saturates", v, MAXC);

        // R4: saturation of a bin
        for (int j = 0; j < 40; j++) send(therm(5), 0);
        rd(5, v); check("R4 bin saturates", v, MAXC);
        rd(6, v); check("R4 neighbour untouched", v, 1);

        // R6: clear and sample on the same edge
        send(therm(9), 1);
        rd(9, v); check("R6 clear wins over sample", v, 0);
        rd(16, v); check("R6 error cleared", v, 0);
        send(therm(9), 0);
        rd(9, v); check("R6 counting after clear", v, 1);

        // R7 R8: graph mode
        do_reset();
        graph_mode = 1;
        seq[0] = therm(3); seq[1] = therm(0); seq[2] = therm(15); seq[3] = therm(7);
        seq[4] = 15'h0101; seq[5] = therm(9); seq[6] = therm(1); seq[7] = therm(12);
        seq[8] = therm(4); seq[9] = therm(6); seq[10] = therm(8); seq[11] = 15'h4000;
        for (int i = 0; i < 12; i++) begin
            send(seq[i], 0);
            if (i == 7) check("R8 done before full", int'(graph_done), 0);
            if (i == 8) check("R8 done when full", int'(graph_done), 1);
        end
        begin
            int exp_b [GD];
            exp_b = '{3, 0, 15, 7, 9, 1, 12, 4};
            for (int e = 0; e < GD; e++) begin
                rd(32 + e, v); check("R7 R8 graph entry", v, exp_b[e]);
            end
        end
        rd(3, v); check("R7 histogram untouched", v, 0);
        rd(16, v); check("R5 errors in graph mode", v, 2);
        check("R8 done held", int'(graph_done), 1);
        @(negedge clk); clear = 1; @(negedge clk); clear = 0;
        check("R6 done cleared", int'(graph_done), 0);
        send(therm(2), 0);
        rd(32, v); check("R6 R7 graph restarts", v, 2);
        graph_mode = 0;

        // R9: low-pass filter, model computed in bench
        do_reset();
        acc = 0;
        for (int i = 0; i < 14; i++) begin
            logic [14:0] p;
            bit ok;
            int ei, ed;
            // ups, bubble with centre set, up, alternating, then downs
            case (i)
                0, 1:          p = therm(10);
                2:             p = 15'h0180;
                3:             p = therm(8);
                4, 6, 8:       p = therm(12);
                5, 7, 9:       p = therm(2);
                default:       p = therm(0);
            endcase
            ok = ((32'(p) & (32'(p) + 1)) == 0);
            ei = 0; ed = 0;
            if (ok) begin
                acc += p[7] ? 1 : -1;
                if (acc == TH) begin ei = 1; acc = 0; end
                if (acc == -TH) begin ed = 1; acc = 0; end
            end
            send(p, 0);
            check("R9 inc", int'(dly_inc), ei);
            check("R9 dec", int'(dly_dec), ed);
        end
        @(negedge clk);
        check("R9 pulse one cycle", int'(dly_inc | dly_dec), 0);

        finish_run();
    end
endmodule